// File: doc/BRIEF.md
# Stepped Logarithmic Volume Ramp

This block sets the level of a stereo digital volume control. It holds the current attenuation as a 7-bit code. On each sample strobe it can move that code one step of 1 dB toward an effective target. A 3-bit dwell select sets how many sample periods pass between two steps, from 1 up to 128.

The effective target is chosen in a fixed order:
- A mute request or a loss-of-sync flag forces full silence.
- Otherwise, when fixed-level mode is selected, the target is unity gain.
- Otherwise, the target is the programmed code.

When mute is released or sync returns, the ramp climbs back to the programmed value. Because the programmed value is never overwritten, nothing extra has to be stored to return to the earlier level.

Both channels of 18-bit signed samples are scaled by the current code. The gain comes from a six-entry mantissa table, one entry per dB inside a 6 dB octave, followed by an arithmetic right shift. Results are rounded toward zero and saturated for the positive-gain codes.

Top module: `vol_ramp_atten`

## Requirements
- R1: After reset, att_code is 0x00, att_silent is 1 and both sample outputs are 0.
- R2: A code of 0x14 or below means silence. A target in that range drives att_code to 0x00. att_silent is 1 exactly when att_code is 0x00, and the sample outputs are 0 while it is.
- R3: att_code changes by exactly one step. From 0x00 an upward step goes to 0x15, and from 0x15 a downward step goes to 0x00; all other steps are +1 or -1. The code never passes the effective target.
- R4: With dwell select n, a step happens on the 2^n-th sample strobe of a movement in one direction. The count starts at rest, or right after the previous step. Clock cycles without a strobe do not count.
- R5: When the direction of movement reverses, the dwell count starts again from zero. This holds even on the strobe that would otherwise have completed the dwell.
- R6: While mute_req is 1, the effective target is 0x00. After release, the code ramps back to the programmed target.
- R7: While sync_lost is 1, the effective target is 0x00. After it clears, the code ramps back to the programmed target.
- R8: With fixed_0db set and neither mute_req nor sync_lost active, the effective target is 0x79 (0 dB) and target_code is ignored.
- R9: The attenuation in dB is code minus 121. Let k = 127 - code, q = k/6 and r = k mod 6. Each output equals (sample × M[r]) / 2^(14+q), truncated toward zero, where M = {32768, 29205, 26029, 23198, 20675, 18427}. It appears one clock after the code and the sample are present.
- R10: Results outside the 18-bit signed range saturate to 131071 or -131072. Negative results round toward zero; for example, -3 at code 0x78 gives -2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_stb | input | 1 | One-cycle strobe per sample period |
| target_code | input | 7 | Programmed attenuation code |
| dwell_sel | input | 3 | Dwell select; 2^n sample periods per step |
| mute_req | input | 1 | Mute request, active high |
| sync_lost | input | 1 | Loss-of-sync flag, active high |
| fixed_0db | input | 1 | Fixed-level mode, unity gain target |
| left_in | input | 18 | Left sample, signed |
| right_in | input | 18 | Right sample, signed |
| att_code | output | 7 | Current attenuation code |
| att_silent | output | 1 | High when the level is full silence |
| left_out | output | 18 | Scaled left sample, signed |
| right_out | output | 18 | Scaled right sample, signed |

## Verification
Two events can land on the same sample strobe: a direction reversal and the strobe that completes a dwell. The bench provokes this with a two-period dwell. The ramp moves upward, and mute is raised so that the reversal arrives exactly on the second strobe. The check expects the code to hold on that strobe and to step down only on the next one. The same coincidence is run again in reverse when mute is released mid-ramp.

// File: rtl/vol_ramp_pkg.sv
// Package: shared constants and the per-dB mantissa table for the
// stepped volume ramp. Assumes a 7-bit code where code-121 is the gain in dB.
package vol_ramp_pkg;
    localparam int CODE_W    = 7;
    localparam int MANT_W    = 17;
    localparam int FRAC_W    = 15;
    localparam int OCT_STEPS = 6;
    localparam logic [CODE_W-1:0] CODE_SILENT = 7'h00;
    localparam logic [CODE_W-1:0] CODE_FLOOR  = 7'h15;
    localparam logic [CODE_W-1:0] CODE_LIMIT  = 7'h14;
    localparam logic [CODE_W-1:0] CODE_UNITY  = 7'h79;
    localparam logic [CODE_W-1:0] CODE_TOP    = 7'h7F;

    // Mantissa of 10^(-r/20) in Q1.15 for the r-th dB inside an octave.
    function automatic logic [MANT_W-1:0] step_mant(input logic [2:0] r);
        case (r)
            3'd0:    step_mant = 17'd32768;
            3'd1:    step_mant = 17'd29205;
            3'd2:    step_mant = 17'd26029;
            3'd3:    step_mant = 17'd23198;
            3'd4:    step_mant = 17'd20675;
            default: step_mant = 17'd18427;
        endcase
    endfunction
endpackage

// File: rtl/vol_ramp_seq.sv
// Ramp sequencer: chooses the effective target (mute/sync > fixed level >
// programmed code) and walks the current code one step per dwell interval.
// Assumes sample_stb is a single-cycle pulse per sample period.
module vol_ramp_seq
    import vol_ramp_pkg::*;
#(
    parameter int DWELL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [CODE_W-1:0] target_code,
    input  logic [DWELL_W-1:0] dwell_sel,
    input  logic              mute_req,
    input  logic              sync_lost,
    input  logic              fixed_0db,
    output logic [CODE_W-1:0] cur_code
);
    localparam int CNT_W = 1 << DWELL_W;

    logic [CODE_W-1:0] tgt_raw, tgt;
    logic [CODE_W-1:0] cur_q, next_code;
    logic [CNT_W:0]    cnt_q, cnt_eff, cnt_inc, limit;
    logic              dir_up_q, go_up, go_down, moving;
    logic              past_valid;

    // Effective target selection with silence normalisation.
    always_comb begin
        if (mute_req || sync_lost) tgt_raw = CODE_SILENT;
        else if (fixed_0db)        tgt_raw = CODE_UNITY;
        else                       tgt_raw = target_code;
        tgt = (tgt_raw <= CODE_LIMIT) ? CODE_SILENT : tgt_raw;
    end

    // Direction, dwell limit and the next code one step away.
    always_comb begin
        go_up   = tgt > cur_q;
        go_down = tgt < cur_q;
        moving  = go_up || go_down;
        limit   = (CNT_W+1)'(1) << dwell_sel;
        cnt_eff = (moving && (go_up != dir_up_q)) ? '0 : cnt_q;
        cnt_inc = cnt_eff + 1'b1;
        if (go_up) next_code = (cur_q == CODE_SILENT) ? CODE_FLOOR : cur_q + 1'b1;
        else       next_code = (cur_q == CODE_FLOOR) ? CODE_SILENT : cur_q - 1'b1;
    end

    // Step state: code, dwell counter and last direction, advanced on strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= CODE_SILENT;
            cnt_q    <= '0;
            dir_up_q <= 1'b0;
        end else if (sample_stb) begin
            if (!moving) begin
                cnt_q <= '0;
            end else if (cnt_inc >= limit) begin
                cur_q    <= next_code;
                cnt_q    <= '0;
                dir_up_q <= go_up;
            end else begin
                cnt_q    <= cnt_inc;
                dir_up_q <= go_up;
            end
        end
    end

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    assign cur_code = cur_q;

    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && cur_q != $past(cur_q)) |->
        (($past(cur_q) == CODE_SILENT && cur_q == CODE_FLOOR) ||
         ($past(cur_q) == CODE_FLOOR && cur_q == CODE_SILENT) ||
         (cur_q == $past(cur_q) + 7'd1) || (cur_q == $past(cur_q) - 7'd1)));

    a_r4_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !$past(sample_stb)) |-> $stable(cur_q));

    a_r3_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(cur_q) < $past(tgt)) |-> (cur_q <= $past(tgt)));

    a_r3_no_overshoot_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(cur_q) > $past(tgt)) |-> (cur_q >= $past(tgt)));
endmodule

// File: rtl/vol_gain_lane.sv
// One channel of gain: mantissa multiply, arithmetic shift by octave,
// round toward zero and saturate. Registered output, one clock of latency.
// Assumes code is 0x00 or within 0x15..0x7F.
module vol_gain_lane
    import vol_ramp_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CODE_W-1:0]        code,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] dout
);
    localparam int PROD_W = DATA_W + MANT_W + 1;
    localparam logic signed [PROD_W-1:0] MAX_V = PROD_W'((1 << (DATA_W-1)) - 1);
    localparam logic signed [PROD_W-1:0] MIN_V = -PROD_W'(1 << (DATA_W-1));

    logic [CODE_W-1:0]        k, q;
    logic [2:0]               r;
    logic [5:0]               sh;
    logic signed [PROD_W-1:0] prod, bias, shifted;
    logic signed [DATA_W-1:0] sat;
    logic                     past_valid;

    // Octave/step split of the code and the scaled, clamped result.
    always_comb begin
        k       = CODE_TOP - code;
        q       = k / CODE_W'(OCT_STEPS);
        r       = 3'(k % CODE_W'(OCT_STEPS));
        sh      = 6'(FRAC_W - 1) + 6'(q);
        prod    = PROD_W'(din) * $signed({1'b0, step_mant(r)});
        bias    = (prod < 0) ? ((PROD_W'(1) <<< sh) - 1'b1) : '0;
        shifted = (prod + bias) >>> sh;
        if (shifted > MAX_V)      sat = MAX_V[DATA_W-1:0];
        else if (shifted < MIN_V) sat = MIN_V[DATA_W-1:0];
        else                      sat = shifted[DATA_W-1:0];
    end

    // Output register; silence forces zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                   dout <= '0;
        else if (code == CODE_SILENT) dout <= '0;
        else                          dout <= sat;
    end

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    a_r2_silent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(code) == CODE_SILENT) |-> (dout == '0));

    a_r10_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(din) >= 0) |-> (dout >= 0));
endmodule

// File: rtl/vol_ramp_atten.sv
// Top: stereo stepped volume ramp. One sequencer drives the shared code;
// a generate loop instantiates one gain lane per channel.
module vol_ramp_atten
    import vol_ramp_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int DWELL_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_stb,
    input  logic [CODE_W-1:0]         target_code,
    input  logic [DWELL_W-1:0]        dwell_sel,
    input  logic                      mute_req,
    input  logic                      sync_lost,
    input  logic                      fixed_0db,
    input  logic signed [DATA_W-1:0]  left_in,
    input  logic signed [DATA_W-1:0]  right_in,
    output logic [CODE_W-1:0]         att_code,
    output logic                      att_silent,
    output logic signed [DATA_W-1:0]  left_out,
    output logic signed [DATA_W-1:0]  right_out
);
    localparam int N_CH = 2;

    logic [CODE_W-1:0]        code_w;
    logic signed [DATA_W-1:0] lane_in  [N_CH];
    logic signed [DATA_W-1:0] lane_out [N_CH];

    vol_ramp_seq #(.DWELL_W(DWELL_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .target_code(target_code), .dwell_sel(dwell_sel),
        .mute_req(mute_req), .sync_lost(sync_lost), .fixed_0db(fixed_0db),
        .cur_code(code_w)
    );

    assign lane_in[0] = left_in;
    assign lane_in[1] = right_in;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
        vol_gain_lane #(.DATA_W(DATA_W)) lane_i (
            .clk(clk), .rst_n(rst_n), .code(code_w),
            .din(lane_in[ch]), .dout(lane_out[ch])
        );
    end

    assign att_code   = code_w;
    assign att_silent = (code_w == CODE_SILENT);
    assign left_out   = lane_out[0];
    assign right_out  = lane_out[1];
endmodule

// File: tb/vol_ramp_atten_tb_top.sv
// Scoreboard bench: driver tasks queue expected values, a negedge monitor
// pops and compares them against the ports.
module vol_ramp_atten_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_stb = 1'b0;
    logic [6:0]        target_code = 7'h00;
    logic [2:0]        dwell_sel = 3'd0;
    logic              mute_req = 1'b0;
    logic              sync_lost = 1'b0;
    logic              fixed_0db = 1'b0;
    logic signed [17:0] left_in = '0;
    logic signed [17:0] right_in = '0;
    logic [6:0]        att_code;
    logic              att_silent;
    logic signed [17:0] left_out, right_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct { int sel; int exp; string tag; } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    vol_ramp_atten dut_i (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .target_code(target_code), .dwell_sel(dwell_sel),
        .mute_req(mute_req), .sync_lost(sync_lost), .fixed_0db(fixed_0db),
        .left_in(left_in), .right_in(right_in),
        .att_code(att_code), .att_silent(att_silent),
        .left_out(left_out), .right_out(right_out)
    );

    // Monitor: pop every pending expectation and compare with the ports.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            int act;
            it = sb.pop_front();
            case (it.sel)
                0: act = int'(att_code);
                1: act = int'(att_silent);
                2: act = int'(left_out);
                default: act = int'(right_out);
            endcase
            n_cmp++;
            if (act != it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
            end
        end
    end

    function automatic int gain_model(int code, int x);
        int m [6] = '{32768, 29205, 26029, 23198, 20675, 18427};
        longint p, res;
        int k;
        if (code <= 8'h14) return 0;
        k = 127 - code;
        p = longint'(x) * m[k % 6];
        res = p / (longint'(1) << (14 + k / 6));
        if (res > 131071) res = 131071;
        if (res < -131072) res = -131072;
        return int'(res);
    endfunction

    task automatic strobe(int n);
        repeat (n) begin
            @(posedge clk); #1 sample_stb = 1'b1;
            @(posedge clk); #1 sample_stb = 1'b0;
        end
    endtask

    task automatic expect_code(int c, string tag);
        sb.push_back('{0, c, tag});
        sb.push_back('{1, (c == 0) ? 1 : 0, tag});
    endtask

    task automatic expect_data(int code, int l, int r, string tag);
        left_in = 18'(l);
        right_in = 18'(r);
        @(posedge clk); @(posedge clk); #1;
        sb.push_back('{2, gain_model(code, l), tag});
        sb.push_back('{3, gain_model(code, r), tag});
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        left_in = 18'sd5000; right_in = -18'sd5000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        expect_code(0, "R1 reset code");
        sb.push_back('{2, 0, "R1 reset left"});
        sb.push_back('{3, 0, "R1 reset right"});

        // R3 leaving silence, dwell 1
        target_code = 7'h18;
        strobe(1); expect_code(8'h15, "R3 leave silence to floor");
        strobe(3); expect_code(8'h18, "R3 reach target");
        strobe(2); expect_code(8'h18, "R3 hold at target");

        // R4 dwell of 4 strobes, idle clocks not counted
        dwell_sel = 3'd2; target_code = 7'h1A;
        strobe(3); expect_code(8'h18, "R4 before 4th strobe");
        strobe(1); expect_code(8'h19, "R4 on 4th strobe");
        repeat (12) @(posedge clk); #1;
        strobe(3); expect_code(8'h19, "R4 idle clocks not counted");
        strobe(1); expect_code(8'h1A, "R4 second step");

        // R5 reversal restarts count
        target_code = 7'h20;
        strobe(2); expect_code(8'h1A, "R5 partial up count");
        target_code = 7'h15;
        strobe(3); expect_code(8'h1A, "R5 restart after reversal");
        strobe(1); expect_code(8'h19, "R5 step after full dwell");

        // R2 target below floor goes to silence
        dwell_sel = 3'd0; target_code = 7'h05;
        strobe(4); expect_code(8'h15, "R2 at floor");
        strobe(1); expect_code(0, "R2 floor to silence");
        expect_data(0, 7000, -9000, "R2 silent outputs zero");

        // R8 fixed level ignores target_code
        fixed_0db = 1'b1;
        strobe(101); expect_code(8'h79, "R8 fixed unity");
        strobe(1); expect_code(8'h79, "R8 hold unity");
        expect_data(8'h79, 12345, -777, "R9 unity gain");

        // R6 mute ramp down and back
        mute_req = 1'b1;
        strobe(50); expect_code(8'h47, "R6 mid mute ramp");
        strobe(51); expect_code(0, "R6 muted silent");
        expect_data(0, 4000, -4000, "R6 muted outputs zero");
        mute_req = 1'b0;
        strobe(1); expect_code(8'h15, "R6 release to floor");
        strobe(100); expect_code(8'h79, "R6 restored level");

        // R7 sync loss, dwell 2
        dwell_sel = 3'd1; sync_lost = 1'b1;
        strobe(1); expect_code(8'h79, "R7 first strobe holds");
        strobe(1); expect_code(8'h78, "R7 step toward silence");
        sync_lost = 1'b0;
        strobe(1); expect_code(8'h78, "R7 restart on return");
        strobe(1); expect_code(8'h79, "R7 restored");

        // R5 reversal coinciding with dwell completion
        fixed_0db = 1'b0; target_code = 7'h7C;
        strobe(1); expect_code(8'h79, "R5 up count one");
        mute_req = 1'b1;
        strobe(1); expect_code(8'h79, "R5 coincident reversal holds");
        strobe(1); expect_code(8'h78, "R5 step after coincidence");
        mute_req = 1'b0;
        strobe(1); expect_code(8'h78, "R6 release restart");
        strobe(7); expect_code(8'h7C, "R6 back to programmed");

        // R10 saturation at +6 dB
        dwell_sel = 3'd0; target_code = 7'h7F;
        strobe(3); expect_code(8'h7F, "R10 top code");
        expect_data(8'h7F, 100000, -100000, "R10 saturate");
        expect_data(8'h7F, 1000, -1000, "R9 double gain");

        // R10 truncation toward zero at -1 dB
        target_code = 7'h78;
        strobe(7); expect_code(8'h78, "R10 minus one dB");
        expect_data(8'h78, 3, -3, "R10 round toward zero");
        expect_data(8'h78, 131071, -131072, "R9 full scale minus one dB");

        // R9 deep attenuation
        target_code = 7'h16;
        strobe(98); expect_code(8'h16, "R9 deep code");
        expect_data(8'h16, 131071, -131072, "R9 deep attenuation");

        @(posedge clk); @(negedge clk); #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule